// File: doc/BRIEF.md
# Microtag-Steered Four-Way Cache Lookup

This block performs lookup and refill control for a small set-associative cache that is indexed with untranslated address bits and tagged with physical addresses. Because the set index and line offset fit inside the page offset, the set can be read before translation completes. A short slice of the virtual tag, the microtag, is compared across the ways of the indexed set. The single way whose microtag matches supplies the speculative data word one cycle after the request. This keeps the wide physical-tag compare off the data path.

The physical tag arrives from the translation stage in the cycle after the request. It confirms or rejects the speculative word. On a rejection the block checks every physical tag in the set. If one matches, a second virtual name of the same physical line is already resident, and the block resolves it in place by moving the requester's microtag onto that line. No memory fetch is needed. If no physical tag matches, the block requests a refill line and stalls new requests until the line is written.

The block keeps two invariants. Valid microtags are unique within every set, and a physical line occupies at most one way of a set. These invariants make the way selection unambiguous.

Top module: `utag_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and `resp_valid`, `spec_valid` and `fill_req` are low, so the first lookup of any set misses.
- R2: A request accepted (`req_valid` and `req_ready` high) at a clock edge is answered by `resp_valid` high during exactly the following cycle; `resp_valid` is low in every other cycle.
- R3: A response is a hit (`resp_hit` high) exactly when a valid way of the set holds the request's microtag and that way's physical tag equals `xlat_ptag`; on a hit `spec_data` is word `req_off` of that line.
- R4: When the microtag matches a valid way but that way's physical tag differs from `xlat_ptag`, `spec_valid` is high and `resp_hit` is low: the speculative word is rejected.
- R5: A miss whose physical tag matches no valid way raises `fill_req` from the next cycle, with `fill_idx` and `fill_ptag` naming the line, and holds `req_ready` low until the cycle in which `fill_valid` is sampled; in the cycle after that `fill_req` is low and `req_ready` high. Word k of `fill_line` occupies bits [k*DATA_W +: DATA_W].
- R6: A miss whose physical tag matches a valid way is reported with `resp_alias` high and `resp_hit` low, raises no fill, and leaves `req_ready` high in the next cycle; the matching way takes the request's microtag, any other valid way holding that microtag is invalidated, and a repeat of the request hits.
- R7: A refill is written into the valid way whose microtag equals the request's microtag, when such a way exists.
- R8: Otherwise the refill goes to the lowest-numbered invalid way, and in a full set to the way chosen by a binary pseudo-LRU tree: a node bit of 0 points the victim search at the lower-numbered half, 1 at the upper half, and every hit, alias resolution and refill sets the bits on the touched way's path to point away from it.
- R9: Within each set no two valid ways hold the same microtag or the same physical tag.
- R10: In the response cycle `spec_valid` is high exactly when a valid way of the requested set holds the request's microtag, whatever the physical tag.
- R11: `req_ready` is high only when no request is awaiting its physical tag and no refill is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_idx | input | $clog2(SETS) | Set index from untranslated address bits |
| req_off | input | $clog2(WORDS) | Word offset within the line |
| req_utag | input | UTAG_W | Microtag: low virtual tag bits of the request |
| xlat_ptag | input | PTAG_W | Physical tag, valid in the cycle after the request |
| spec_valid | output | 1 | A way matched the microtag; spec_data comes from it |
| spec_data | output | DATA_W | Speculative data word |
| resp_valid | output | 1 | Hit/miss verdict present |
| resp_hit | output | 1 | Verdict: spec_data is correct |
| resp_alias | output | 1 | Verdict: miss resolved in place against a resident alias |
| fill_req | output | 1 | Refill line requested |
| fill_idx | output | $clog2(SETS) | Set of the requested line |
| fill_ptag | output | PTAG_W | Physical tag of the requested line |
| fill_valid | input | 1 | Refill line present on fill_line |
| fill_line | input | WORDS*DATA_W | Refill line data |

## Verification
The bench builds the block with four sets, four ways, four words per line, a 3-bit microtag and an 8-bit physical tag. With only eight microtag values and a dozen physical lines spread over four sets, the random phase often produces microtag collisions that carry different physical tags, aliases in which the requester's microtag is held by another line, and evictions from full sets. The pseudo-LRU tree is only three bits deep, so its victim order is reached repeatedly. Refill latencies of zero to three cycles exercise the stall window.

// File: rtl/utag_cache_pkg.sv
package utag_cache_pkg;

  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_FILL = 1'b1
  } fsm_e;

endpackage

// File: rtl/utag_match.sv
// Parallel equality compare of one key against every way of a set,
// qualified by the way's valid bit.
module utag_match #(
  parameter int WAYS = 4,
  parameter int KEY_W = 4
) (
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0][KEY_W-1:0] keys_i,
  input  logic [KEY_W-1:0]           key_i,
  output logic [WAYS-1:0]            hit_o
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_o[w] = vld_i[w] && (keys_i[w] == key_i);
  end

endmodule

// File: rtl/utag_pick_first.sv
// Index of the lowest set bit of a vector, plus an any-bit flag.
module utag_pick_first #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = W'(i);
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/utag_plru.sv
// Binary pseudo-LRU tree, heap-ordered node bits (node 0 is the root,
// children of n are 2n+1 and 2n+2). Bit 0 steers to the lower half.
module utag_plru #(
  parameter int WAYS = 4,
  localparam int LW = $clog2(WAYS)
) (
  input  logic [WAYS-2:0] bits_i,
  input  logic [LW-1:0]   touch_i,
  output logic [LW-1:0]   victim_o,
  output logic [WAYS-2:0] bits_o
);

  always_comb begin
    int n;
    n = 0;
    for (int l = 0; l < LW; l++) begin
      n = 2 * n + 1 + int'(bits_i[n]);
    end
    victim_o = LW'(n - (WAYS - 1));
  end

  always_comb begin
    int n;
    logic d;
    bits_o = bits_i;
    n = 0;
    for (int l = 0; l < LW; l++) begin
      d = touch_i[LW-1-l];
      bits_o[n] = ~d;
      n = 2 * n + 1 + int'(d);
    end
  end

endmodule

// File: rtl/utag_cache.sv
module utag_cache
  import utag_cache_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int UTAG_W = 4,
  parameter int PTAG_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [$clog2(SETS)-1:0]    req_idx,
  input  logic [$clog2(WORDS)-1:0]   req_off,
  input  logic [UTAG_W-1:0]          req_utag,
  input  logic [PTAG_W-1:0]          xlat_ptag,
  output logic                       spec_valid,
  output logic [DATA_W-1:0]          spec_data,
  output logic                       resp_valid,
  output logic                       resp_hit,
  output logic                       resp_alias,
  output logic                       fill_req,
  output logic [$clog2(SETS)-1:0]    fill_idx,
  output logic [PTAG_W-1:0]          fill_ptag,
  input  logic                       fill_valid,
  input  logic [WORDS*DATA_W-1:0]    fill_line
);

  localparam int IDX_W  = $clog2(SETS);
  localparam int LW     = $clog2(WAYS);
  localparam int LINE_W = WORDS * DATA_W;

  // ---------------- storage ----------------
  logic [SETS-1:0][WAYS-1:0]              vld_q, vld_d;
  logic [SETS-1:0][WAYS-1:0][UTAG_W-1:0]  utag_q;
  logic [SETS-1:0][WAYS-1:0][PTAG_W-1:0]  ptag_q;
  logic [SETS-1:0][WAYS-1:0][LINE_W-1:0]  line_q;
  logic [SETS-1:0][WAYS-2:0]              plru_q, plru_d;

  // ---------------- control state ----------------
  fsm_e               state_q, state_d;
  logic               s1_vld_q, s1_vld_d;
  logic [IDX_W-1:0]   s1_idx_q;
  logic [UTAG_W-1:0]  s1_utag_q;
  logic [LW-1:0]      s1_way_q;
  logic               s1_uhit_q;
  logic [DATA_W-1:0]  s1_data_q;
  logic [IDX_W-1:0]   f_idx_q;
  logic [UTAG_W-1:0]  f_utag_q;
  logic [PTAG_W-1:0]  f_ptag_q;
  logic [LW-1:0]      f_way_q;

  logic accept, hit, alias_hit, miss_fill, fill_done;

  assign req_ready = (state_q == ST_RUN) && !s1_vld_q;
  assign accept    = req_valid && req_ready;
  assign fill_done = (state_q == ST_FILL) && fill_valid;

  // ---------------- request cycle: microtag way select ----------------
  logic [WAYS-1:0] req_uvec;
  logic [LW-1:0]   req_way;
  logic            req_uhit;
  logic [LINE_W-1:0] req_line;

  utag_match #(.WAYS(WAYS), .KEY_W(UTAG_W)) u_req_umatch (
    .vld_i  (vld_q[req_idx]),
    .keys_i (utag_q[req_idx]),
    .key_i  (req_utag),
    .hit_o  (req_uvec)
  );

  utag_pick_first #(.N(WAYS)) u_req_enc (
    .vec_i (req_uvec),
    .idx_o (req_way),
    .any_o (req_uhit)
  );

  assign req_line = line_q[req_idx][req_way];

  // ---------------- check cycle: full physical compare ----------------
  logic [WAYS-1:0] chk_pvec;
  logic [LW-1:0]   chk_pway;
  logic            chk_pany;
  logic [LW-1:0]   inv_way;
  logic            inv_any;
  logic [LW-1:0]   plru_vict;
  logic [LW-1:0]   vict_way;

  utag_match #(.WAYS(WAYS), .KEY_W(PTAG_W)) u_chk_pmatch (
    .vld_i  (vld_q[s1_idx_q]),
    .keys_i (ptag_q[s1_idx_q]),
    .key_i  (xlat_ptag),
    .hit_o  (chk_pvec)
  );

  utag_pick_first #(.N(WAYS)) u_chk_enc (
    .vec_i (chk_pvec),
    .idx_o (chk_pway),
    .any_o (chk_pany)
  );

  utag_pick_first #(.N(WAYS)) u_inv_enc (
    .vec_i (~vld_q[s1_idx_q]),
    .idx_o (inv_way),
    .any_o (inv_any)
  );

  assign hit       = s1_vld_q && s1_uhit_q && chk_pvec[s1_way_q];
  assign alias_hit = s1_vld_q && !hit && chk_pany;
  assign miss_fill = s1_vld_q && !hit && !chk_pany;

  // ---------------- replacement ----------------
  logic [IDX_W-1:0] plru_set;
  logic [LW-1:0]    plru_touch;
  logic [WAYS-2:0]  plru_upd;

  assign plru_set   = (state_q == ST_FILL) ? f_idx_q : s1_idx_q;
  assign plru_touch = (state_q == ST_FILL) ? f_way_q :
                      (hit ? s1_way_q : chk_pway);

  utag_plru #(.WAYS(WAYS)) u_plru (
    .bits_i   (plru_q[plru_set]),
    .touch_i  (plru_touch),
    .victim_o (plru_vict),
    .bits_o   (plru_upd)
  );

  // A same-microtag line must go so the microtag stays unique.
  assign vict_way = s1_uhit_q ? s1_way_q : (inv_any ? inv_way : plru_vict);

  // ---------------- next-state logic ----------------
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (miss_fill) state_d = ST_FILL;
      ST_FILL: if (fill_valid) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  assign s1_vld_d = accept;

  always_comb begin
    vld_d = vld_q;
    if (fill_done) vld_d[f_idx_q][f_way_q] = 1'b1;
    if (alias_hit && s1_uhit_q) vld_d[s1_idx_q][s1_way_q] = 1'b0;
  end

  always_comb begin
    plru_d = plru_q;
    if (hit || alias_hit || fill_done) plru_d[plru_set] = plru_upd;
  end

  // ---------------- registers with reset ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      s1_vld_q <= 1'b0;
      vld_q    <= '0;
      plru_q   <= '0;
    end else begin
      state_q  <= state_d;
      s1_vld_q <= s1_vld_d;
      vld_q    <= vld_d;
      plru_q   <= plru_d;
    end
  end

  // ---------------- enabled registers without reset ----------------
  always_ff @(posedge clk) begin
    if (accept) begin
      s1_idx_q  <= req_idx;
      s1_utag_q <= req_utag;
      s1_way_q  <= req_way;
      s1_uhit_q <= req_uhit;
      s1_data_q <= req_line[req_off*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (miss_fill) begin
      f_idx_q  <= s1_idx_q;
      f_utag_q <= s1_utag_q;
      f_ptag_q <= xlat_ptag;
      f_way_q  <= vict_way;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      utag_q[f_idx_q][f_way_q] <= f_utag_q;
      ptag_q[f_idx_q][f_way_q] <= f_ptag_q;
      line_q[f_idx_q][f_way_q] <= fill_line;
    end else if (alias_hit) begin
      utag_q[s1_idx_q][chk_pway] <= s1_utag_q;
    end
  end

  // ---------------- outputs ----------------
  assign spec_valid = s1_vld_q && s1_uhit_q;
  assign spec_data  = s1_data_q;
  assign resp_valid = s1_vld_q;
  assign resp_hit   = hit;
  assign resp_alias = alias_hit;
  assign fill_req   = (state_q == ST_FILL);
  assign fill_idx   = f_idx_q;
  assign fill_ptag  = f_ptag_q;

endmodule

// File: rtl/utag_cache_chk.sv
module utag_cache_chk #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int UTAG_W = 4,
  parameter int PTAG_W = 20
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              req_valid,
  input logic                              req_ready,
  input logic                              spec_valid,
  input logic                              resp_valid,
  input logic                              resp_hit,
  input logic                              resp_alias,
  input logic                              fill_req,
  input logic                              fill_valid,
  input logic [SETS-1:0][WAYS-1:0]             vld_q,
  input logic [SETS-1:0][WAYS-1:0][UTAG_W-1:0] utag_q,
  input logic [SETS-1:0][WAYS-1:0][PTAG_W-1:0] ptag_q
);

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid)
    else $error("R2 response missing after accepted request");

  a_r2_resp_only_after: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready))
    else $error("R2 response without request");

  a_r4_hit_needs_utag: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> (resp_valid && spec_valid))
    else $error("R4 hit without microtag match");

  a_r6_alias_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
    resp_alias |-> (resp_valid && !resp_hit))
    else $error("R6 alias flagged on a hit");

  a_r6_alias_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    resp_alias |=> (!fill_req && req_ready))
    else $error("R6 alias caused a fill or a stall");

  a_r5_miss_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit && !resp_alias) |=> fill_req)
    else $error("R5 plain miss without fill request");

  a_r5_fill_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_valid) |=> (!fill_req && req_ready))
    else $error("R5 fill did not release the stall");

  a_r11_stall_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready)
    else $error("R11 ready while fill pending");

  always @(posedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int i = 0; i < WAYS; i++) begin
          for (int j = i + 1; j < WAYS; j++) begin
            if (vld_q[s][i] && vld_q[s][j]) begin
              a_r9_utag_unique: assert (utag_q[s][i] != utag_q[s][j])
                else $error("R9 duplicate microtag in set %0d", s);
              a_r9_ptag_unique: assert (ptag_q[s][i] != ptag_q[s][j])
                else $error("R9 duplicate physical line in set %0d", s);
            end
          end
        end
      end
    end
  end

endmodule

bind utag_cache utag_cache_chk #(
  .SETS(SETS), .WAYS(WAYS), .UTAG_W(UTAG_W), .PTAG_W(PTAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .spec_valid(spec_valid), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_alias(resp_alias), .fill_req(fill_req), .fill_valid(fill_valid),
  .vld_q(vld_q), .utag_q(utag_q), .ptag_q(ptag_q)
);

// File: tb/utag_cache_tb.sv
module utag_cache_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int WORDS  = 4;
  localparam int DATA_W = 32;
  localparam int UTAG_W = 3;
  localparam int PTAG_W = 8;
  localparam int IDX_W  = $clog2(SETS);
  localparam int OFF_W  = $clog2(WORDS);

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] req_off;
  logic [UTAG_W-1:0] req_utag;
  logic [PTAG_W-1:0] xlat_ptag;
  logic spec_valid, resp_valid, resp_hit, resp_alias, fill_req, fill_valid;
  logic [DATA_W-1:0] spec_data;
  logic [IDX_W-1:0] fill_idx;
  logic [PTAG_W-1:0] fill_ptag;
  logic [WORDS*DATA_W-1:0] fill_line;

  utag_cache #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(DATA_W),
               .UTAG_W(UTAG_W), .PTAG_W(PTAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_off(req_off), .req_utag(req_utag),
    .xlat_ptag(xlat_ptag), .spec_valid(spec_valid), .spec_data(spec_data),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_alias(resp_alias),
    .fill_req(fill_req), .fill_idx(fill_idx), .fill_ptag(fill_ptag),
    .fill_valid(fill_valid), .fill_line(fill_line)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // Reference model: per set/way valid, microtag, physical tag; tree bits.
  int mv [SETS][WAYS];
  int mu [SETS][WAYS];
  int mp [SETS][WAYS];
  int pb [SETS][3];

  function automatic logic [DATA_W-1:0] memw(int p, int s, int w);
    return 32'(p * 32'h9E3779B1) ^ 32'(s << 12) ^ 32'(w << 24) ^ 32'h0BADF00D;
  endfunction

  task automatic chk(string msg, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  function automatic int plru_victim(int s);
    if (pb[s][0] == 0) return (pb[s][1] != 0) ? 1 : 0;
    return (pb[s][2] != 0) ? 3 : 2;
  endfunction

  task automatic touch(int s, int w);
    pb[s][0] = (w < 2) ? 1 : 0;
    if (w < 2) pb[s][1] = (w == 0) ? 1 : 0;
    else       pb[s][2] = (w == 2) ? 1 : 0;
  endtask

  task automatic do_req(int s, int off, int ut, int pt, int fdly, string tag);
    int um, pm, vic;
    bit hit, ali;
    @(negedge clk);
    chk({"R11 ready before request ", tag}, 32'(req_ready), 1);
    chk({"R2 no stray response ", tag}, 32'(resp_valid), 0);
    req_valid = 1'b1; req_idx = IDX_W'(s); req_off = OFF_W'(off);
    req_utag = UTAG_W'(ut);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    xlat_ptag = PTAG_W'(pt);
    #1;
    um = -1; pm = -1;
    for (int w = 0; w < WAYS; w++) begin
      if (mv[s][w] != 0 && mu[s][w] == ut) um = w;
      if (mv[s][w] != 0 && mp[s][w] == pt) pm = w;
    end
    hit = (um >= 0) && (um == pm);
    ali = !hit && (pm >= 0);
    chk({"R2 response valid ", tag}, 32'(resp_valid), 1);
    chk({"R10 spec_valid ", tag}, 32'(spec_valid), 32'(um >= 0));
    if (um >= 0 && !hit)
      chk({"R4 rejected speculative word ", tag}, 32'(resp_hit), 0);
    else
      chk({"R3 hit verdict ", tag}, 32'(resp_hit), 32'(hit));
    chk({"R6 alias flag ", tag}, 32'(resp_alias), 32'(ali));
    chk({"R11 stall during check ", tag}, 32'(req_ready), 0);
    if (hit) chk({"R3 hit data ", tag}, spec_data, memw(pt, s, off));
    if (hit) begin
      touch(s, um);
      @(negedge clk);
      chk("R11 ready after hit", 32'(req_ready), 1);
    end else if (ali) begin
      mu[s][pm] = ut;
      if (um >= 0) mv[s][um] = 0;
      touch(s, pm);
      @(negedge clk);
      chk("R6 no fill after alias", 32'(fill_req), 0);
      chk("R6 ready after alias", 32'(req_ready), 1);
    end else begin
      if (um >= 0) vic = um;
      else begin
        vic = -1;
        for (int w = WAYS - 1; w >= 0; w--) if (mv[s][w] == 0) vic = w;
        if (vic < 0) vic = plru_victim(s);
      end
      @(negedge clk);
      for (int d = 0; d <= fdly; d++) begin
        chk("R5 fill request", 32'(fill_req), 1);
        chk("R5 stall while filling", 32'(req_ready), 0);
        chk("R5 fill set", 32'(fill_idx), 32'(s));
        chk("R5 fill tag", 32'(fill_ptag), 32'(pt));
        if (d < fdly) @(negedge clk);
      end
      fill_valid = 1'b1;
      for (int w = 0; w < WORDS; w++) fill_line[w*DATA_W +: DATA_W] = memw(pt, s, w);
      @(posedge clk);
      @(negedge clk);
      fill_valid = 1'b0;
      chk("R5 fill released", 32'(fill_req), 0);
      chk("R5 ready after fill", 32'(req_ready), 1);
      // R7 / R8: victim choice is verified by the later hit/miss verdicts.
      mv[s][vic] = 1; mu[s][vic] = ut; mp[s][vic] = pt;
      touch(s, vic);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin mv[s][w] = 0; mu[s][w] = 0; mp[s][w] = 0; end
      for (int k = 0; k < 3; k++) pb[s][k] = 0;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_idx = '0; req_off = '0; req_utag = '0;
    xlat_ptag = '0; fill_valid = 1'b0; fill_line = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready after reset", 32'(req_ready), 1);
    chk("R1 no response after reset", 32'(resp_valid), 0);
    chk("R1 no fill after reset", 32'(fill_req), 0);
    chk("R1 no spec after reset", 32'(spec_valid), 0);

    // Cold miss then hits on the same line.
    do_req(0, 0, 1, 8'h10, 2, "R1");
    do_req(0, 1, 1, 8'h10, 0, "R3");
    do_req(0, 3, 1, 8'h10, 0, "R3");
    // Fill the rest of set 0: invalid ways taken lowest first.
    do_req(0, 0, 2, 8'h11, 0, "R8");
    do_req(0, 0, 3, 8'h12, 1, "R8");
    do_req(0, 0, 4, 8'h13, 3, "R8");
    do_req(0, 2, 2, 8'h11, 0, "R8");
    do_req(0, 2, 4, 8'h13, 0, "R8");
    // Microtag matches, physical tag differs: rejected, same way replaced.
    do_req(0, 1, 1, 8'h20, 1, "R4");
    do_req(0, 2, 1, 8'h20, 0, "R7");
    do_req(0, 1, 3, 8'h12, 0, "R7");
    do_req(0, 1, 1, 8'h10, 0, "R7");
    // Full set, new microtag: pseudo-LRU victim.
    do_req(0, 0, 5, 8'h30, 0, "R8");
    do_req(0, 0, 2, 8'h11, 0, "R8");
    do_req(0, 0, 3, 8'h12, 0, "R8");
    do_req(0, 0, 6, 8'h31, 0, "R8");
    // Alias: resident physical line under another microtag.
    do_req(0, 3, 7, 8'h31, 0, "R6");
    do_req(0, 3, 7, 8'h31, 0, "R6");
    do_req(0, 3, 6, 8'h31, 0, "R6");
    // Alias where the requester's microtag sits on another line.
    do_req(0, 1, 3, 8'h11, 0, "R6");
    do_req(0, 1, 3, 8'h11, 0, "R6");
    do_req(0, 1, 2, 8'h12, 0, "R6");
    // Other sets are independent.
    do_req(1, 0, 1, 8'h10, 0, "R3");
    do_req(1, 0, 1, 8'h10, 0, "R3");

    // Random mix over few microtags and physical lines: collisions,
    // aliases and evictions; uniqueness (R9) shows in every verdict.
    for (int i = 0; i < 1500; i++) begin
      do_req(int'($urandom_range(0, SETS - 1)), int'($urandom_range(0, WORDS - 1)),
             int'($urandom_range(0, 7)), int'($urandom_range(1, 12)),
             int'($urandom_range(0, 3)), "R9");
    end

    summary();
    $finish;
  end

endmodule